// File: doc/BRIEF.md
# Pipelined Bus Memory Target with Wait States and Error Response

This block is a bus target for an AHB-Lite system. It sits in front of a small array of 32-bit words. In the address phase it takes the request: select, transfer type, direction and byte address. It keeps that request in registers and carries out the access in the next cycle, the data phase. The live address is never used in the data phase, because by then the bus already carries the address of the following transfer.

Every in-range access completes after a fixed number of stall cycles, set by `WAIT_CYCLES`. During the stall, the ready output is held low and the captured request is frozen. An address that lies beyond the last word gets a two-cycle error reply. That address leaves the array untouched.

New transfers can be issued back to back. Burst beats are serviced one at a time, each exactly like a single transfer. The block sits behind an external address decoder. Its ready input is the bus-wide ready, which in a one-target system is its own ready output fed back.

Top module: `ahbl_wait_mem`

## Requirements
- R1: A transfer is active only when `sel_i` is high and `trans_i[1]` is 1 (2'b10 first beat, 2'b11 following beat). Idle (2'b00) and busy (2'b01) transfers, and unselected ones, cause no stall, no error and no write. With no active transfer in its data phase, `readyout_o` is 1 and `resp_o` is 0.
- R2: The request (active flag, direction, word index, range flag) is captured only on a clock edge where `ready_i` is 1. At any other edge it holds its value.
- R3: The data phase acts on the captured word index, not on the live `addr_i`. A write to word X that is followed at once by the address phase of word Y stores into X. A read of X issued right after a write to X returns the new data.
- R4: An active in-range write stores `wdata_i` at the edge where its data phase completes. An active in-range read shows the stored word on `rdata_o` in its completion cycle.
- R5: An active in-range transfer holds `readyout_o` low for exactly `WAIT_CYCLES` data-phase cycles, then drives it high with `resp_o` 0.
- R6: The word index is `addr_i[ADDR_W-1:2]`. When this index is at least `DEPTH_WORDS`, the reply takes two cycles. In the first, `resp_o`=1 and `readyout_o`=0. In the second, `resp_o`=1 and `readyout_o`=1.
- R7: Burst beats (following-beat type with incrementing word addresses) are each captured and serviced exactly like single transfers.
- R8: Asserting `rst_n` low clears the captured request. After reset, `readyout_o`=1, `resp_o`=0 and `rdata_o`=0.
- R9: An errored write leaves every stored word unchanged, including the word its lower index bits alias to. An errored read returns zero on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Target select from the decoder |
| addr_i | input | ADDR_W | Byte address, address phase |
| write_i | input | 1 | 1 = write, 0 = read |
| trans_i | input | 2 | Transfer type |
| size_i | input | 3 | Transfer size (always a full word here; not decoded) |
| wdata_i | input | DATA_W | Write data, data phase |
| ready_i | input | 1 | Bus-wide ready, marks transfer boundaries |
| rdata_o | output | DATA_W | Read data, data phase |
| readyout_o | output | 1 | Data phase completes when high |
| resp_o | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
Every output depends only on registers. The bench therefore reads the data-phase status at the falling edge of each cycle, and drives the next address phase and the pending write data at that same edge. An in-range transfer captured at edge k must show `WAIT_CYCLES` low-ready cycles and then complete. An out-of-range one must show exactly one low-ready error cycle and then a high-ready error cycle. The bench counts the low-ready cycles and compares the count with these figures. Write data is committed to the reference array only at the edge that ends the data phase. Read data is compared in the completion cycle, so back-to-back writes and reads to the same word check the one-cycle pipeline offset.

// File: rtl/ahbl_mem_pkg.sv
package ahbl_mem_pkg;

  // Data-phase state of the target
  typedef enum logic [1:0] {
    PH_OKAY = 2'd0,   // idle or completing with OKAY
    PH_WAIT = 2'd1,   // stalling an in-range access
    PH_ERR1 = 2'd2,   // first error cycle, ready low
    PH_ERR2 = 2'd3    // second error cycle, ready high
  } phase_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

endpackage

// File: rtl/ahbl_addr_capture.sv
module ahbl_addr_capture #(
  parameter int ADDR_W      = 12,
  parameter int DEPTH_WORDS = 64,
  localparam int WORD_W     = ADDR_W - 2,
  localparam int IDX_W      = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_i,
  input  logic              sel_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              new_act_o,
  output logic              new_inr_o,
  output logic              act_q,
  output logic              wr_q,
  output logic              inr_q,
  output logic [IDX_W-1:0]  idx_q
);

  logic             act_d, wr_d, inr_d;
  logic [IDX_W-1:0] idx_d;
  logic             cap_en;
  logic [WORD_W-1:0] word;

  assign word = addr_i[ADDR_W-1:2];

  // Range check: a full-size array needs no compare
  generate
    if (DEPTH_WORDS >= (2 ** WORD_W)) begin : g_full
      assign new_inr_o = 1'b1;
    end else begin : g_part
      assign new_inr_o = ({1'b0, word} < (WORD_W + 1)'(DEPTH_WORDS));
    end
  endgenerate

  assign new_act_o = sel_i & trans_i[1];
  assign cap_en    = ready_i;

  always_comb begin
    act_d = new_act_o;
    wr_d  = write_i;
    inr_d = new_inr_o;
    idx_d = addr_i[IDX_W+1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      inr_q <= 1'b0;
      idx_q <= '0;
    end else if (cap_en) begin
      act_q <= act_d;
      wr_q  <= wr_d;
      inr_q <= inr_d;
      idx_q <= idx_d;
    end
  end

  // R2: captured request frozen while the bus is stalled
  assert_hold_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable({act_q, wr_q, inr_q, idx_q}));

endmodule

// File: rtl/ahbl_resp_ctrl.sv
module ahbl_resp_ctrl
  import ahbl_mem_pkg::*;
#(
  parameter int WAIT_CYCLES = 2,
  localparam int CNT_W      = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1,
  localparam int LOW_LIM    = (WAIT_CYCLES > 0) ? WAIT_CYCLES : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic new_act_i,
  input  logic new_inr_i,
  output logic readyout_o,
  output logic resp_o
);

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_OKAY, PH_ERR2: begin
        if (ready_i) begin
          if (new_act_i && !new_inr_i) begin
            st_d = PH_ERR1;
          end else if (new_act_i && (WAIT_CYCLES > 0)) begin
            st_d  = PH_WAIT;
            cnt_d = CNT_W'(WAIT_CYCLES);
          end else begin
            st_d = PH_OKAY;
          end
        end
      end
      PH_WAIT: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) st_d = PH_OKAY;
      end
      PH_ERR1: st_d = PH_ERR2;
      default: st_d = PH_OKAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_OKAY;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign readyout_o = (st_q == PH_OKAY) || (st_q == PH_ERR2);
  assign resp_o     = (st_q == PH_ERR1) || (st_q == PH_ERR2);

  // Length of the current low-ready run, for the bound check only
  logic [15:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run_q <= '0;
    else if (readyout_o)  low_run_q <= '0;
    else                  low_run_q <= low_run_q + 16'd1;
  end

  // R1: an inactive address phase leaves an OKAY, ready data phase
  assert_idle_okay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !new_act_i) |=> (readyout_o && !resp_o));

  // R5: ready never low longer than the configured latency
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !readyout_o |-> (low_run_q < 16'(LOW_LIM)));

  generate
    if (WAIT_CYCLES > 0) begin : g_wait_chk
      // R5: a captured in-range access stalls in its first data cycle
      assert_wait_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && readyout_o && new_act_i && new_inr_i) |=> (!readyout_o && !resp_o));
    end
  endgenerate

  // R6: error starts with ready low
  assert_err_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_o) |-> !readyout_o);

  // R6: second error cycle keeps ERROR and raises ready
  assert_err_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && !readyout_o) |=> (resp_o && readyout_o));

endmodule

// File: rtl/ahbl_word_store.sv
module ahbl_word_store #(
  parameter int DATA_W      = 32,
  parameter int DEPTH_WORDS = 64,
  localparam int IDX_W      = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH_WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = rd_en_i ? mem[idx_i] : '0;

endmodule

// File: rtl/ahbl_wait_mem.sv
module ahbl_wait_mem #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int DEPTH_WORDS = 64,
  parameter int WAIT_CYCLES = 2,
  localparam int IDX_W      = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [1:0]        trans_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              readyout_o,
  output logic              resp_o
);

  logic             new_act, new_inr;
  logic             act_q, wr_q, inr_q;
  logic [IDX_W-1:0] idx_q;
  logic             mem_we, mem_rd;
  logic             unused_ok;

  // Word-only target: size and byte offset are not decoded
  assign unused_ok = ^{size_i, addr_i[1:0]};

  ahbl_addr_capture #(
    .ADDR_W      (ADDR_W),
    .DEPTH_WORDS (DEPTH_WORDS)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_i   (ready_i),
    .sel_i     (sel_i),
    .trans_i   (trans_i),
    .write_i   (write_i),
    .addr_i    (addr_i),
    .new_act_o (new_act),
    .new_inr_o (new_inr),
    .act_q     (act_q),
    .wr_q      (wr_q),
    .inr_q     (inr_q),
    .idx_q     (idx_q)
  );

  ahbl_resp_ctrl #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .new_act_i  (new_act),
    .new_inr_i  (new_inr),
    .readyout_o (readyout_o),
    .resp_o     (resp_o)
  );

  // Data phase acts on the captured request only
  assign mem_we = act_q & wr_q & inr_q & readyout_o;
  assign mem_rd = act_q & ~wr_q & inr_q;

  ahbl_word_store #(
    .DATA_W      (DATA_W),
    .DEPTH_WORDS (DEPTH_WORDS)
  ) u_store (
    .clk     (clk),
    .we_i    (mem_we),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .rd_en_i (mem_rd),
    .rdata_o (rdata_o)
  );

  // R9: an error reply never carries read data
  assert_err_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_o |-> (rdata_o == '0));

endmodule

// File: tb/test_ahbl_wait_mem.sv
module test_ahbl_wait_mem;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int WAITS  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sel_i;
  logic [ADDR_W-1:0] addr_i;
  logic              write_i;
  logic [1:0]        trans_i;
  logic [2:0]        size_i;
  logic [DATA_W-1:0] wdata_i;
  logic [DATA_W-1:0] rdata_o;
  logic              readyout_o;
  logic              resp_o;

  always #10 clk = ~clk;   // 50 MHz

  ahbl_wait_mem #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH_WORDS (DEPTH), .WAIT_CYCLES (WAITS)
  ) i_ahbl_wait_mem (
    .clk (clk), .rst_n (rst_n), .sel_i (sel_i), .addr_i (addr_i),
    .write_i (write_i), .trans_i (trans_i), .size_i (size_i), .wdata_i (wdata_i),
    .ready_i (readyout_o), .rdata_o (rdata_o), .readyout_o (readyout_o), .resp_o (resp_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [DATA_W-1:0] model [DEPTH];

  // Pending transfer now in its data phase
  bit                p_act = 0, p_wr = 0, p_inr = 0;
  int                p_word = 0;
  logic [DATA_W-1:0] p_wdata = '0;

  function automatic logic [DATA_W-1:0] pattern(input int w, input int salt);
    return DATA_W'(32'hA5000000 ^ (w * 32'h01010101) ^ (salt << 8));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Drive one address phase (at a falling edge) and service the pending data phase
  task automatic beat(input bit sel, input logic [1:0] tr, input bit wr,
                      input int word, input logic [DATA_W-1:0] wd);
    int  lows = 0;
    bit  fin  = 0;
    sel_i   = sel;
    trans_i = tr;
    write_i = wr;
    addr_i  = ADDR_W'(word * 4);
    wdata_i = p_wdata;
    while (!fin) begin
      if (!p_act) begin
        chk(readyout_o == 1'b1 && resp_o == 1'b0, "R1", "idle data phase ready/resp",
            {30'd0, readyout_o, resp_o}, 32'd2);
        fin = 1;
      end else if (!readyout_o) begin
        lows++;
        if (!p_inr) chk(resp_o == 1'b1, "R6", "first error cycle resp", resp_o, 1);
        else        chk(resp_o == 1'b0, "R5", "wait cycle resp", resp_o, 0);
        if (lows > WAITS + 2) begin
          chk(0, "R5", "ready stuck low", lows, WAITS);
          fin = 1;
        end else begin
          @(posedge clk); @(negedge clk);
        end
      end else begin
        if (!p_inr) begin
          chk(resp_o == 1'b1 && lows == 1, "R6", "second error cycle / low count",
              lows, 1);
          if (!p_wr) chk(rdata_o == '0, "R9", "errored read data", rdata_o, '0);
        end else begin
          chk(resp_o == 1'b0 && lows == WAITS, "R5", "stall length", lows, WAITS);
          if (p_wr) model[p_word] = p_wdata;
          else chk(rdata_o == model[p_word], "R4", "read data (R3 captured index)",
                   rdata_o, model[p_word]);
        end
        fin = 1;
      end
    end
    @(posedge clk); @(negedge clk);
    p_act   = sel && tr[1];
    p_wr    = wr;
    p_inr   = (word < DEPTH);
    p_word  = word;
    p_wdata = wd;
  endtask

  task automatic idle();
    beat(0, 2'b00, 0, 0, '0);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; sel_i = 0; addr_i = '0; write_i = 0; trans_i = 2'b00;
    size_i = 3'b010; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: reset state
    chk(readyout_o && !resp_o && rdata_o == '0, "R8", "post-reset outputs",
        {rdata_o[DATA_W-1:2], readyout_o, resp_o}, 32'd2);

    // R7: burst fill of every word, then burst read back
    for (int i = 0; i < DEPTH; i++) beat(1, i == 0 ? 2'b10 : 2'b11, 1, i, pattern(i, 1));
    for (int i = 0; i < DEPTH; i++) beat(1, i == 0 ? 2'b10 : 2'b11, 0, i, '0);
    idle();

    // R3: write X then immediately address Y, then read X back-to-back
    beat(1, 2'b10, 1, 5, 32'h1234_5678);
    beat(1, 2'b10, 1, 6, 32'h0BAD_F00D);
    beat(1, 2'b10, 0, 5, '0);
    beat(1, 2'b10, 0, 6, '0);
    idle();

    // R9: errored write aliasing word 5, errored read, then read word 5
    beat(1, 2'b10, 1, DEPTH + 5, '0);
    beat(1, 2'b10, 0, DEPTH + 5, '0);
    beat(1, 2'b10, 1, DEPTH + 5, 32'hDEAD_BEEF);  // data for errored write above was '0
    beat(1, 2'b10, 0, 5, '0);
    idle();

    // R1: busy, idle-with-select and unselected writes are ignored
    beat(1, 2'b01, 1, 7, 32'hFFFF_0001);
    beat(1, 2'b00, 1, 7, 32'hFFFF_0002);
    beat(0, 2'b10, 1, 7, 32'hFFFF_0003);
    beat(1, 2'b10, 0, 7, '0);
    idle();

    // Random mix
    for (int n = 0; n < 500; n++) begin
      int  r    = int'($urandom_range(0, 99));
      bit  sel  = (r < 90);
      logic [1:0] tr = 2'($urandom_range(0, 3));
      bit  wr   = 1'($urandom_range(0, 1));
      int  word = ($urandom_range(0, 9) == 0) ? int'($urandom_range(DEPTH, 1023))
                                               : int'($urandom_range(0, DEPTH - 1));
      beat(sel, tr, wr, word, $urandom());
    end
    idle();

    // R8: reset in the middle of a stall
    beat(1, 2'b10, 0, 3, '0);
    chk(readyout_o == 1'b0, "R5", "stall before reset", readyout_o, 0);
    rst_n = 0;
    sel_i = 0; trans_i = 2'b00;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    p_act = 0;
    chk(readyout_o && !resp_o && rdata_o == '0, "R8", "outputs after mid-stall reset",
        {rdata_o[DATA_W-1:2], readyout_o, resp_o}, 32'd2);
    @(negedge clk);
    beat(1, 2'b10, 0, 3, '0);
    idle();

    summary();
  end

endmodule